// File: doc/BRIEF.md
# Host-Controlled Domain Reset and RAM-Clear Sequencer

This block sits on a simple host register bus and decides when each of six functional domains of a chip leaves reset. The six domains are system, four receive lines and one receive protection-switching domain. A master reset register holds the whole device in reset while it contains the key byte 0x91, and it holds that value after hardware reset. Each domain also has its own reset register. Writing the key byte to a domain's register puts that domain into reset, but only while the master register also holds the key. Any other byte written to a domain's register takes the domain out of reset, at any time.

When the master reset is released, every domain clears its local RAM. It writes zeros through a one-port write interface, one address per cycle. A domain's sweep moves forward only while that domain's clock-running input is high and the domain is not held in reset. A status word reports which domains have finished. The operational-enable output stays low until all domains are out of reset and cleared and software has set the initialized bit. Writing the key back into the master register restarts the whole sequence.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After hardware reset the master register reads 0x91, every `dom_rst` bit is 1, `op_en` is 0, `mem_we` is 0 and the status word at offset 0x07 reads 0x00.
- R2: The master register at offset 0x00 stores any written byte. While it holds 0x91 every `dom_rst` bit is 1. When it holds any other value, a domain's reset depends only on that domain's own register.
- R3: Domain registers sit at offsets 0x01 to 0x06 (system, line 1 to line 4, protection), and domain k drives `dom_rst[k-1]`. Writing 0x91 to one while the master holds 0x91 asserts that domain's reset: the register reads back 0x91 and the domain stays in reset after the master is released.
- R4: A write of 0x91 to a domain register while the master does not hold 0x91 is ignored. The register still reads 0x00 and the domain's `dom_rst` stays 0.
- R5: Writing any value other than 0x91 to a domain register deasserts that domain's reset. It then reads 0x00, whatever the master holds.
- R6: After the master is released, each domain writes zero to addresses 0 to DEPTH-1 in rising order, one per cycle. The domain's address field is `mem_addr[k*AW +: AW]`. If the domain is free to run, its first write is in the cycle that follows the release write. No write occurs while a domain is in reset.
- R7: A sweep pauses and keeps its address while the domain's `dom_clk_ok` bit is 0 or the domain is held in reset. It resumes at the same address.
- R8: Bit k of the read-only status word at offset 0x07 sets when domain k has written its last address. Bit 0 is system, bits 1 to 4 are lines 1 to 4, and bit 5 is protection.
- R9: `op_en` is 1 only when bit 0 of the initialized register at offset 0x08 is 1, all six status bits are 1 and no `dom_rst` bit is 1.
- R10: Writing 0x91 to the master clears all status bits and the initialized bit. Writes to the initialized bit are ignored while the master holds 0x91.
- R11: `bus_rvalid` is 1 exactly in the cycle after a cycle with `bus_rd` high, and `bus_rdata` carries the addressed value. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock, used for every domain |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| dom_clk_ok | input | 6 | Per-domain clock-running indication |
| dom_rst | output | 6 | Per-domain reset, active high |
| mem_we | output | 6 | Per-domain RAM-clear write enable |
| mem_addr | output | 6*AW | Per-domain RAM-clear address, AW bits per domain |
| mem_wdata | output | DW | RAM-clear write data, always zero |
| op_en | output | 1 | Device operational enable |

## Verification
A corrupted sweep address shows at the RAM port in the very next write: the bench tracks every write per domain against an independent count, so a skipped, repeated or paused-wrong address is reported on that cycle. A wrong master or domain register value appears at once on `dom_rst` or on the one-cycle read-back. A done flag that is set too early, or one that survives a master re-assert, shows as a wrong status word or a premature `op_en` at the next check.

// File: rtl/rst_seq_pkg.sv
// Package: shared constants and types for the reset sequencer.
// Assumes a fixed six-domain register map; offsets below are decoded by the host.
package rst_seq_pkg;
    localparam int          NUM_DOM   = 6;
    localparam int          REG_AW    = 4;
    localparam int          REG_DW    = 8;
    localparam logic [7:0]  RST_KEY   = 8'h91;
    localparam logic [3:0]  OFF_GLOB  = 4'h0;
    localparam int          OFF_DOM0  = 1;
    localparam logic [3:0]  OFF_DONE  = 4'h7;
    localparam logic [3:0]  OFF_INIT  = 4'h8;

    typedef enum logic {
        SW_CLEARING = 1'b0,
        SW_FINISHED = 1'b1
    } sweep_st_e;
endpackage

// File: rtl/rst_seq_regs.sv
// Module: host register file of the sequencer.
// Holds the master reset byte, one reset bit per domain, and the initialized bit.
// Assumes single-cycle write strobes; reads are registered (one cycle latency).
module rst_seq_regs
    import rst_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [REG_AW-1:0]   addr,
    input  logic [REG_DW-1:0]   wdata,
    input  logic [NUM_DOM-1:0]  done_in,
    output logic [REG_DW-1:0]   rdata,
    output logic                rvalid,
    output logic                glob_hold,
    output logic [NUM_DOM-1:0]  dom_sw,
    output logic                init_flag
);
    logic [REG_DW-1:0] glob_q;
    logic [REG_DW-1:0] rd_mux;

    // Master reset byte; starts out holding the key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_q <= RST_KEY;
        else if (wr && addr == OFF_GLOB)
            glob_q <= wdata;
    end

    assign glob_hold = (glob_q == RST_KEY);

    // One reset bit per domain: set only under master hold, cleared by any non-key.
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        always_ff @(posedge clk) begin
            if (!rst_n)
                dom_sw[g] <= 1'b0;
            else if (wr && addr == REG_AW'(OFF_DOM0 + g)) begin
                if (wdata != RST_KEY)
                    dom_sw[g] <= 1'b0;
                else if (glob_hold)
                    dom_sw[g] <= 1'b1;
            end
        end
    end

    // Initialized bit; forced low while the master holds the key.
    always_ff @(posedge clk) begin
        if (!rst_n || glob_hold)
            init_flag <= 1'b0;
        else if (wr && addr == OFF_INIT)
            init_flag <= wdata[0];
    end

    // Read multiplexer over the word offsets.
    always_comb begin
        rd_mux = '0;
        if (addr == OFF_GLOB)
            rd_mux = glob_q;
        else if (addr == OFF_DONE)
            rd_mux = REG_DW'(done_in);
        else if (addr == OFF_INIT)
            rd_mux = REG_DW'(init_flag);
        for (int i = 0; i < NUM_DOM; i++) begin
            if (addr == REG_AW'(OFF_DOM0 + i))
                rd_mux = dom_sw[i] ? RST_KEY : '0;
        end
    end

    // Registered read data and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd;
            if (rd)
                rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/rst_seq_sweep.sv
// Module: RAM-clear sweep engine for one domain.
// Writes addresses 0..DEPTH-1 once per master release, one per cycle, pausing
// while the domain clock is not running or the domain is in reset.
// Assumes DEPTH >= 2.
module rst_seq_sweep
    import rst_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glob_hold,
    input  logic          dom_hold,
    input  logic          clk_ok,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic          done
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sweep_st_e st_q;

    assign we   = (st_q == SW_CLEARING) && clk_ok && !dom_hold && !glob_hold;
    assign done = (st_q == SW_FINISHED);

    // Sweep state and address; a master hold rearms the sweep from address 0.
    always_ff @(posedge clk) begin
        if (!rst_n || glob_hold) begin
            st_q <= SW_CLEARING;
            addr <= '0;
        end else if (we) begin
            if (addr == LAST) begin
                st_q <= SW_FINISHED;
                addr <= '0;
            end else begin
                addr <= addr + AW'(1);
            end
        end
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
// Module: top of the host-controlled multi-domain reset sequencer.
// Combines the register file with one sweep engine per domain and gates the
// operational enable. All domains share clk; dom_clk_ok models clock presence.
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [REG_AW-1:0]      bus_addr,
    input  logic [REG_DW-1:0]      bus_wdata,
    output logic [REG_DW-1:0]      bus_rdata,
    output logic                   bus_rvalid,
    input  logic [NUM_DOM-1:0]     dom_clk_ok,
    output logic [NUM_DOM-1:0]     dom_rst,
    output logic [NUM_DOM-1:0]     mem_we,
    output logic [NUM_DOM*AW-1:0]  mem_addr,
    output logic [DW-1:0]          mem_wdata,
    output logic                   op_en
);
    logic               glob_hold;
    logic               init_flag;
    logic [NUM_DOM-1:0] dom_sw;
    logic [NUM_DOM-1:0] done_vec;

    rst_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .done_in   (done_vec),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .glob_hold (glob_hold),
        .dom_sw    (dom_sw),
        .init_flag (init_flag)
    );

    // Effective domain reset: master hold or the domain's own bit.
    assign dom_rst = {NUM_DOM{glob_hold}} | dom_sw;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_sweep
        rst_seq_sweep #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
            .clk       (clk),
            .rst_n     (rst_n),
            .glob_hold (glob_hold),
            .dom_hold  (dom_rst[g]),
            .clk_ok    (dom_clk_ok[g]),
            .we        (mem_we[g]),
            .addr      (mem_addr[g*AW +: AW]),
            .done      (done_vec[g])
        );
    end

    assign mem_wdata = '0;

    // Operation starts only when software says so and every domain is ready.
    assign op_en = init_flag && (&done_vec) && !(|dom_rst);
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
// Module: property checker for rst_seq_ctrl, attached by bind below.
// Observes ports plus the master-hold and done signals of the top.
module rst_seq_ctrl_chk
    import rst_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_rd,
    input logic                   bus_rvalid,
    input logic [NUM_DOM-1:0]     dom_rst,
    input logic [NUM_DOM-1:0]     mem_we,
    input logic [NUM_DOM*AW-1:0]  mem_addr,
    input logic                   op_en,
    input logic                   glob_hold,
    input logic [NUM_DOM-1:0]     done_vec
);
    // Read valid follows the strobe by exactly one cycle.
    p_rvalid_after_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_no_stray_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // No RAM-clear write reaches a domain that is in reset.
    p_no_write_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we & dom_rst) == '0);

    // Operational enable needs every domain finished and released.
    p_op_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_en |-> ((&done_vec) && !(|dom_rst)));

    // Re-entering master hold wipes the status word.
    p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_hold) |=> (done_vec == '0));

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        // Consecutive addresses, or wrap to 0 at the end of a sweep.
        p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we[g] |=> ((mem_addr[g*AW +: AW] == $past(mem_addr[g*AW +: AW]) + AW'(1))
                           || (mem_addr[g*AW +: AW] == '0)));
        // Address holds while no write happens outside master hold.
        p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!mem_we[g] && !glob_hold) |=> $stable(mem_addr[g*AW +: AW]));
    end
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .dom_rst    (dom_rst),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .op_en      (op_en),
    .glob_hold  (glob_hold),
    .done_vec   (done_vec)
);

// File: tb/rst_seq_ctrl_bench.sv
// Bench: register vector table walked by one loop, then directed sweep,
// pause, status and enable tests. Inputs change 4 ns after a rising edge;
// results are sampled on falling edges.
module rst_seq_ctrl_bench;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int ND    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              bus_rvalid;
    logic [ND-1:0]     dom_clk_ok = '0;
    logic [ND-1:0]     dom_rst;
    logic [ND-1:0]     mem_we;
    logic [ND*AW-1:0]  mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic              op_en;

    int  n_checks = 0;
    int  n_errors = 0;
    int  wcnt [ND];
    logic clr_cnt = 1'b1;

    always #10 clk = ~clk;

    rst_seq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rst_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .dom_clk_ok(dom_clk_ok), .dom_rst(dom_rst),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .op_en(op_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_pt();
        @(posedge clk);
        #4;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        drive_pt();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        drive_pt();
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        drive_pt();
        bus_rd = 1'b1; bus_addr = a;
        drive_pt();
        bus_rd = 1'b0;
        @(negedge clk);
        check({req, " rvalid"}, 32'(bus_rvalid), 32'd1);
        check({req, " rdata"}, 32'(bus_rdata), 32'(exp));
    endtask

    // Write monitor: each domain's writes must walk 0..DEPTH-1 with zero data (R6).
    always @(negedge clk) begin
        if (clr_cnt) begin
            for (int d = 0; d < ND; d++) wcnt[d] = 0;
        end else begin
            for (int d = 0; d < ND; d++) begin
                if (mem_we[d]) begin
                    check("R6 sweep address", 32'(mem_addr[d*AW +: AW]), 32'(wcnt[d]));
                    check("R6 zero data", mem_wdata, 32'd0);
                    wcnt[d] = wcnt[d] + 1;
                end
            end
        end
    end

    // Vector: {is_read, req_no[3:0], offset[3:0], data_or_expect[7:0]}
    localparam int NV = 22;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'd3,  4'h1, 8'h91},   // R3 assert system domain under hold
        {1'b1, 4'd3,  4'h1, 8'h91},
        {1'b0, 4'd5,  4'h1, 8'h55},   // R5 non-key clears
        {1'b1, 4'd5,  4'h1, 8'h00},
        {1'b0, 4'd3,  4'h2, 8'h91},
        {1'b1, 4'd3,  4'h2, 8'h91},
        {1'b1, 4'd11, 4'h9, 8'h00},   // R11 unmapped
        {1'b1, 4'd8,  4'h7, 8'h00},   // R8 nothing cleared yet
        {1'b0, 4'd10, 4'h8, 8'h01},   // R10 init write under hold
        {1'b1, 4'd10, 4'h8, 8'h00},
        {1'b0, 4'd2,  4'h0, 8'h42},   // R2 release master
        {1'b1, 4'd2,  4'h0, 8'h42},
        {1'b0, 4'd4,  4'h3, 8'h91},   // R4 key ignored without hold
        {1'b1, 4'd4,  4'h3, 8'h00},
        {1'b0, 4'd5,  4'h2, 8'h00},   // R5 deassert with master released
        {1'b1, 4'd5,  4'h2, 8'h00},
        {1'b0, 4'd2,  4'h0, 8'h91},
        {1'b1, 4'd2,  4'h0, 8'h91},
        {1'b0, 4'd3,  4'h6, 8'h91},   // R3 hold protection domain
        {1'b0, 4'd2,  4'h0, 8'h00},
        {1'b1, 4'd3,  4'h6, 8'h91},
        {1'b1, 4'd5,  4'h1, 8'h00}
    };

    initial begin
        repeat (3) @(posedge clk);
        #4 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dom_rst", 32'(dom_rst), 32'h3f);
        check("R1 op_en", 32'(op_en), 32'd0);
        check("R1 mem_we", 32'(mem_we), 32'd0);
        reg_rd(4'h0, 8'h91, "R1 master");
        reg_rd(4'h7, 8'h00, "R1 status");
        clr_cnt = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][16])
                reg_rd(VEC[i][11:8], VEC[i][7:0], $sformatf("R%0d table step %0d", VEC[i][15:12], i));
            else
                reg_wr(VEC[i][11:8], VEC[i][7:0]);
        end
        // R2 master released: only the protection domain stays held (R3)
        check("R2 dom_rst after release", 32'(dom_rst), 32'h20);
        check("R7 no write without clock", 32'(mem_we), 32'd0);

        // Lines 1..4 run; system paused by clock; protection held in reset.
        drive_pt();
        dom_clk_ok = 6'b111110;
        repeat (DEPTH + 3) @(posedge clk);
        @(negedge clk);
        for (int d = 1; d <= 4; d++) check("R6 line sweep count", 32'(wcnt[d]), DEPTH);
        check("R7 paused by clock", 32'(wcnt[0]), 32'd0);
        check("R7 paused by reset", 32'(wcnt[5]), 32'd0);
        reg_rd(4'h7, 8'h1e, "R8 partial status");
        check("R9 op_en before done", 32'(op_en), 32'd0);

        // R7: run system domain 5 cycles, pause, resume.
        drive_pt();
        dom_clk_ok[0] = 1'b1;
        repeat (5) @(posedge clk);
        #4 dom_clk_ok[0] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 pause count", 32'(wcnt[0]), 32'd5);
        drive_pt();
        dom_clk_ok[0] = 1'b1;
        reg_wr(4'h6, 8'h00);     // R5 release protection domain
        repeat (DEPTH + 3) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < ND; d++) check("R6 full sweep count", 32'(wcnt[d]), DEPTH);
        reg_rd(4'h7, 8'h3f, "R8 all done");
        check("R9 op_en without init", 32'(op_en), 32'd0);
        reg_wr(4'h8, 8'h01);
        check("R9 op_en after init", 32'(op_en), 32'd1);
        reg_rd(4'h8, 8'h01, "R9 init readback");

        // R10: re-assert master, check wipe, then release with all clocks running.
        clr_cnt = 1'b1;
        reg_wr(4'h0, 8'h91);
        @(negedge clk);
        check("R10 op_en low", 32'(op_en), 32'd0);
        check("R10 dom_rst all", 32'(dom_rst), 32'h3f);
        reg_rd(4'h7, 8'h00, "R10 status wiped");
        reg_rd(4'h8, 8'h00, "R10 init wiped");
        clr_cnt = 1'b0;
        reg_wr(4'h0, 8'h00);
        check("R6 first write cycle", 32'(mem_we), 32'h3f);
        check("R6 first address", 32'(mem_addr), 32'd0);
        repeat (DEPTH + 3) @(posedge clk);
        @(negedge clk);
        reg_rd(4'h7, 8'h3f, "R8 status after rerun");
        check("R10 op_en waits for init", 32'(op_en), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule